// File: doc/BRIEF.md
# Block-Lock Write Protection Unit

This unit decides, for a pending nonvolatile commit, whether each array byte or the single control byte may be written. The control byte is an 8-bit register at the top of the address space. It holds a lock-level field that fences off the top quarter, the top half or all of the array. It also holds a protect-enable bit that lets an external write-protect pin take effect. The array size is a parameter, a power of two from 4 bytes upward; 2K, 8K and 16K bytes are the intended values.

The serial front end stays outside this unit. That front end marks the start of each write sequence, reports every byte it loads while the control byte is targeted, and pulses a commit when it sees the start-write pattern. The unit holds the staged byte and counts the loaded bytes. It raises a latch-clear request when a control-byte sequence has to be dropped. The array permit is combinational, so the front end can query it for every byte address of a page.

Top module: `blk_lock_guard`

## Requirements
- R1: The control byte resets to 00h. Bit 7 is the protect-enable bit (PE), bit 3 is lock bit high and bit 2 is lock bit low. Every other bit is stored as 0 and reads as 0 on `ctrl_o`, whatever value was loaded.
- R2: The lock level {bit 3, bit 2} selects the fenced region. 00 fences nothing. 01 fences array offsets from 3/4 of DEPTH upward. 10 fences offsets from DEPTH/2 upward. 11 fences the whole array. `arr_wr_ok_o` is 1 only for an address that is neither fenced nor a control-byte access (`reg_sel_i`=1).
- R3: An address with any bit set above the array index width is never writable as an array byte.
- R4: A fenced array byte is refused, and an unfenced one is permitted, for every combination of the pin and PE.
- R5: Hardware protection is active exactly when `wp_pin_i`=0 and PE=1. While it is active, `reg_wr_ok_o` is 0 and a commit leaves the control byte unchanged, so PE cannot clear itself.
- R6: With the pin high or PE=0, a sequence that loads exactly one byte and then commits makes the masked byte visible on `ctrl_o` after the commit edge.
- R7: If a second byte is loaded into the control byte in one sequence, that sequence is aborted until the next `seq_start_i`. During the abort `reg_wr_ok_o`=0, `wel_clr_o`=1 while `reg_sel_i`=1, and a commit has no effect.
- R8: If hardware protection is seen at any clock during a control-byte sequence before its commit, the sequence is cancelled, even when the pin returns high before the commit. `wel_clr_o` then stays 1 while `reg_sel_i`=1, and the commit has no effect.
- R9: `wel_clr_o` is 1 whenever `reg_sel_i`=1 and hardware protection is active. It is 0 for a valid pending one-byte sequence.
- R10: The control byte changes only on a clock where `commit_i`=1 and `reg_wr_ok_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Target byte address of the pending commit |
| reg_sel_i | input | 1 | The sequence targets the control byte |
| wp_pin_i | input | 1 | Write-protect pin, low requests protection |
| seq_start_i | input | 1 | A new write sequence begins; clears count and cancel |
| byte_load_i | input | 1 | One byte loaded this clock |
| load_data_i | input | 8 | Byte being loaded |
| commit_i | input | 1 | Start-write pattern recognised |
| arr_wr_ok_o | output | 1 | Array byte at `addr_i` may be written |
| reg_wr_ok_o | output | 1 | A commit now would update the control byte |
| wel_clr_o | output | 1 | Request to clear the write-enable latch |
| ctrl_o | output | 8 | Current control byte |

## Verification
The hardest state to reach is a cancelled control-byte sequence whose pin is high again at commit time. The inputs at that moment look the same as those of a valid one-byte sequence. PE must first be set with the pin high. A byte is then staged, the pin is pulsed low for one clock and released, and only then is the commit issued. The bench checks that the register keeps its value and that a fresh sequence afterwards succeeds. The region decode is swept over every lock level, both pin levels and both PE values, for all array offsets and a band of out-of-range addresses.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;
  localparam int PE_BIT  = 7;
  localparam int LK1_BIT = 3;
  localparam int LK0_BIT = 2;
  localparam logic [7:0] CTRL_MASK = 8'h8C;

  typedef enum logic [1:0] {
    LOCK_NONE = 2'b00,
    LOCK_QTR  = 2'b01,
    LOCK_HALF = 2'b10,
    LOCK_ALL  = 2'b11
  } lock_lvl_e;

  function automatic lock_lvl_e lvl_of(logic [7:0] r);
    return lock_lvl_e'({r[LK1_BIT], r[LK0_BIT]});
  endfunction
endpackage

// File: rtl/blk_lock_region.sv
module blk_lock_region
  import blk_lock_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 2048
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  lock_lvl_e         lvl_i,
  output logic              in_range_o,
  output logic              locked_o
);
  localparam int AW       = $clog2(DEPTH);
  localparam int QTR_BASE = (DEPTH / 4) * 3;
  localparam int HALF_BASE = DEPTH / 2;

  logic [AW-1:0] ofs;
  assign ofs = addr_i[AW-1:0];

  generate
    if (AW < ADDR_W) begin : g_hi
      assign in_range_o = ~|addr_i[ADDR_W-1:AW];
    end else begin : g_full
      assign in_range_o = 1'b1;
    end
  endgenerate

  always_comb begin
    unique case (lvl_i)
      LOCK_NONE: locked_o = 1'b0;
      LOCK_QTR:  locked_o = (32'(ofs) >= QTR_BASE);
      LOCK_HALF: locked_o = (32'(ofs) >= HALF_BASE);
      default:   locked_o = 1'b1;
    endcase
  end

  always_comb begin
    if (lvl_i == LOCK_NONE) p_none_open_r2: assert (!locked_o);
    if (lvl_i == LOCK_ALL)  p_all_shut_r2:  assert (locked_o);
  end
endmodule

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl
  import blk_lock_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_sel_i,
  input  logic       hw_prot_i,
  input  logic       seq_start_i,
  input  logic       byte_load_i,
  input  logic [7:0] load_data_i,
  input  logic       commit_i,
  output logic [7:0] ctrl_o,
  output logic       reg_wr_ok_o,
  output logic       abort_o,
  output logic       cancel_o
);
  logic [7:0] ctrl_q, stage_q;
  logic [1:0] cnt_q;
  logic       cancel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      stage_q  <= '0;
      cnt_q    <= '0;
      cancel_q <= 1'b0;
    end else begin
      if (commit_i && reg_wr_ok_o) ctrl_q <= stage_q;
      if (seq_start_i) begin
        cnt_q    <= '0;
        cancel_q <= 1'b0;
      end else begin
        if (byte_load_i && reg_sel_i) begin
          if (cnt_q == 2'd0) stage_q <= load_data_i & CTRL_MASK;
          if (cnt_q != 2'd2) cnt_q <= cnt_q + 2'd1;
        end
        // protection seen mid-sequence is sticky until the next start
        if (reg_sel_i && hw_prot_i) cancel_q <= 1'b1;
      end
    end
  end

  assign reg_wr_ok_o = reg_sel_i & ~hw_prot_i & ~cancel_q & (cnt_q == 2'd1);
  assign abort_o     = (cnt_q == 2'd2);
  assign cancel_o    = cancel_q;
  assign ctrl_o      = ctrl_q;

  p_rsvd_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q & ~CTRL_MASK) == 8'h00);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_i && reg_wr_ok_o) |=> $stable(ctrl_q));
  p_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && reg_wr_ok_o) |=> ctrl_q == $past(stage_q));
  p_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !reg_wr_ok_o);
endmodule

// File: rtl/blk_lock_guard.sv
module blk_lock_guard
  import blk_lock_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              reg_sel_i,
  input  logic              wp_pin_i,
  input  logic              seq_start_i,
  input  logic              byte_load_i,
  input  logic [7:0]        load_data_i,
  input  logic              commit_i,
  output logic              arr_wr_ok_o,
  output logic              reg_wr_ok_o,
  output logic              wel_clr_o,
  output logic [7:0]        ctrl_o
);
  logic hw_prot, in_range, locked, abort, cancel;

  assign hw_prot = ~wp_pin_i & ctrl_o[PE_BIT];

  blk_lock_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_sel_i   (reg_sel_i),
    .hw_prot_i   (hw_prot),
    .seq_start_i (seq_start_i),
    .byte_load_i (byte_load_i),
    .load_data_i (load_data_i),
    .commit_i    (commit_i),
    .ctrl_o      (ctrl_o),
    .reg_wr_ok_o (reg_wr_ok_o),
    .abort_o     (abort),
    .cancel_o    (cancel)
  );

  blk_lock_region #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_region (
    .addr_i     (addr_i),
    .lvl_i      (lvl_of(ctrl_o)),
    .in_range_o (in_range),
    .locked_o   (locked)
  );

  // the pin never loosens or tightens array fencing
  assign arr_wr_ok_o = ~reg_sel_i & in_range & ~locked;
  assign wel_clr_o   = reg_sel_i & (hw_prot | abort | cancel);

  p_reg_not_arr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_i |-> !arr_wr_ok_o);
  p_all_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[LK1_BIT] && ctrl_o[LK0_BIT]) |-> !arr_wr_ok_o);
  p_hw_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wp_pin_i && ctrl_o[PE_BIT]) |-> !reg_wr_ok_o);
  p_pe_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wp_pin_i && ctrl_o[PE_BIT]) |=> ctrl_o[PE_BIT]);
  p_clr_hw_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i && !wp_pin_i && ctrl_o[PE_BIT]) |-> wel_clr_o);
endmodule

// File: tb/test_blk_lock_guard.sv
`timescale 1ns/1ps
module test_blk_lock_guard;
  localparam int ADDR_W = 16;
  localparam int DEPTH  = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic reg_sel = 0, wp = 1, seq_start = 0, byte_load = 0, commit = 0;
  logic [7:0] ldata = '0;
  logic arr_ok, reg_ok, wel_clr;
  logic [7:0] ctrl;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  blk_lock_guard #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_blk_lock_guard (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .reg_sel_i(reg_sel),
    .wp_pin_i(wp), .seq_start_i(seq_start), .byte_load_i(byte_load),
    .load_data_i(ldata), .commit_i(commit), .arr_wr_ok_o(arr_ok),
    .reg_wr_ok_o(reg_ok), .wel_clr_o(wel_clr), .ctrl_o(ctrl));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_seq();
    @(negedge clk); seq_start = 1; reg_sel = 1;
    @(negedge clk); seq_start = 0;
  endtask

  task automatic load(input logic [7:0] b);
    @(negedge clk); byte_load = 1; ldata = b;
    @(negedge clk); byte_load = 0;
  endtask

  task automatic do_commit();
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0; reg_sel = 0;
  endtask

  task automatic set_ctrl(input logic [7:0] b);
    start_seq(); load(b); do_commit();
  endtask

  function automatic bit exp_ok(int a, int lvl);
    if (a >= DEPTH) return 0;
    case (lvl)
      0: return 1;
      1: return a < (DEPTH / 4) * 3;
      2: return a < DEPTH / 2;
      default: return 0;
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset value", ctrl, 8'h00);

    // R1: reserved bits dropped
    set_ctrl(8'hFF);
    check("R1 masked load", ctrl, 8'h8C);
    set_ctrl(8'h73);
    check("R1 masked load 2", ctrl, 8'h00);

    // R2 R3 R4: sweep lock levels, PE, pin, addresses
    for (int lvl = 0; lvl < 4; lvl++) begin
      for (int pe = 0; pe < 2; pe++) begin
        wp = 1;
        set_ctrl(8'((pe << 7) | (lvl << 2)));
        check("R6 ctrl after commit", ctrl, (pe << 7) | (lvl << 2));
        for (int w = 0; w < 2; w++) begin
          wp = w[0];
          for (int a = 0; a < DEPTH + 64; a++) begin
            addr = ADDR_W'(a); #1;
            check($sformatf("R2/R4 lvl=%0d pe=%0d wp=%0d addr=%0h", lvl, pe, w, a),
                  arr_ok, exp_ok(a, lvl));
          end
          addr = 16'hFFFF; #1;
          check("R3 top address", arr_ok, 0);
          addr = 16'h8000; #1;
          check("R3 high bit", arr_ok, 0);
          addr = 16'h0000; reg_sel = 1; #1;
          check("R2 reg_sel blocks array", arr_ok, 0);
          reg_sel = 0;
        end
      end
    end

    // R6: PE=0 with pin low still allows a write
    wp = 1; set_ctrl(8'h00);
    wp = 0; set_ctrl(8'h04);
    check("R6 write with pin low PE=0", ctrl, 8'h04);
    wp = 1;

    // R5: set PE, then pin low blocks register, PE self-locks
    set_ctrl(8'h88);
    check("R6 set PE", ctrl, 8'h88);
    wp = 0;
    start_seq(); load(8'h00);
    #1 check("R5 reg_wr_ok under protection", reg_ok, 0);
    check("R9 wel_clr under protection", wel_clr, 1);
    do_commit();
    check("R5 PE stays set", ctrl, 8'h88);

    // R8: pin pulses low mid-sequence, then high before commit
    wp = 1;
    start_seq();
    #1 check("R9 wel_clr low on fresh sequence", wel_clr, 0);
    load(8'h04);
    #1 check("R9 valid sequence no clear", wel_clr, 0);
    check("R6 reg_wr_ok valid", reg_ok, 1);
    @(negedge clk); wp = 0;
    @(negedge clk); wp = 1;
    #1 check("R8 cancelled reg_wr_ok", reg_ok, 0);
    check("R8 cancelled wel_clr", wel_clr, 1);
    do_commit();
    check("R8 commit ignored", ctrl, 8'h88);

    // R6 after cancel: fresh sequence clears PE
    set_ctrl(8'h04);
    check("R6 PE cleared with pin high", ctrl, 8'h04);

    // R7: two bytes abort
    start_seq(); load(8'h0C); load(8'h08);
    #1 check("R7 abort reg_wr_ok", reg_ok, 0);
    check("R7 abort wel_clr", wel_clr, 1);
    do_commit();
    check("R7 commit ignored", ctrl, 8'h04);
    @(negedge clk); reg_sel = 1;
    #1 check("R7 abort persists", reg_ok, 0);
    reg_sel = 0;

    // R10: commit with no byte loaded, and load without commit
    start_seq(); do_commit();
    check("R10 empty commit", ctrl, 8'h04);
    start_seq(); load(8'h08);
    @(negedge clk); reg_sel = 0;
    repeat (3) @(negedge clk);
    check("R10 no commit no change", ctrl, 8'h04);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule